// File: doc/BRIEF.md
# ALU with Registered Condition Flags

This block is the arithmetic core of a small 16-bit datapath. A purely combinational unit takes two operands, a 3-bit operation code and a 4-bit shift amount. It produces a result the same cycle, from one of eight operations: add, subtract, bitwise AND, bitwise OR, logical left shift, logical right shift, arithmetic right shift and rotate left.

Beside it sits a 3-bit status register holding zero, overflow and negative. The surrounding pipeline reads this register to resolve conditional branches. The register is written on a rising clock edge only when the caller raises the flag-write enable and the selected operation is one of the four arithmetic or logic operations. Shifts and rotates always leave the flags alone.

The negative flag reflects the true sign of the mathematical result. It is the result's top bit exchanged (XOR) with the overflow condition, so a signed comparison made by subtraction stays correct when the difference overflows. The operands, the operation code and the enable are plain level inputs with no handshake. The result is valid whenever the inputs are stable, and the flags are valid from the cycle after the edge that wrote them.

Top module: `alu_flags_unit`

## Requirements
- R1: With op_sel 000 the result is (a + b) mod 2^16, and with op_sel 001 it is (a - b) mod 2^16, available combinationally.
- R2: With op_sel 010 the result is a AND b, and with op_sel 011 it is a OR b.
- R3: op_sel 100 shifts a left logically, 101 shifts it right logically, 110 shifts it right arithmetically and 111 rotates it left, by shamt (0 to 15) positions. A shamt of 0 returns a unchanged.
- R4: After an edge with flag_we high and op_sel in 000..011, flag_z is 1 exactly when that operation's result was zero.
- R5: After such an edge with add or subtract, flag_v is 1 exactly when the signed 16-bit result cannot be represented, meaning the mathematical sum or difference of the signed operands lies outside -32768..32767.
- R6: After such an edge with add or subtract, flag_n equals result bit 15 XOR the overflow condition.
- R7: After such an edge with AND or OR, flag_v and flag_n are both 0.
- R8: An edge with op_sel 100..111 leaves all three flags unchanged, even with flag_we high.
- R9: An edge with flag_we low leaves all three flags unchanged.
- R10: An edge with rst high clears flag_z, flag_v and flag_n to 0. The reset is synchronous, active high, and takes priority over flag_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 3 | Operation code (see R1 to R3) |
| opnd_a | input | 16 | First operand, also the value that is shifted or rotated |
| opnd_b | input | 16 | Second operand |
| shamt | input | 4 | Unsigned shift or rotate amount |
| flag_we | input | 1 | Allows an arithmetic or logic operation to write the flags |
| result | output | 16 | Combinational operation result |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered signed-overflow flag |
| flag_n | output | 1 | Registered negative flag (sign XOR overflow) |

## Verification
Directed vectors go first. Adding the largest positive values, and subtracting across the sign boundary, separates true overflow from a plain wrap. These cases also show whether the negative flag follows the sign-XOR-overflow rule or the raw top bit. Equal operands under subtraction and disjoint masks under AND give a zero result, which exercises the zero flag. Shift amounts of 0, 1 and 15 on a value with its top bit set tell the arithmetic shift apart from the logical one, and the rotate apart from the left shift. Several thousand random vectors follow, with random enable and occasional reset. A behavioural model compares the result and each flag after every clock, which covers the interplay of the flag-write gating with the operation class.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLL = 3'd4,
    OP_SRL = 3'd5,
    OP_SRA = 3'd6,
    OP_ROL = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shift_mode_e;

  typedef struct packed {
    logic z;
    logic v;
    logic n;
  } cond_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  // subtraction as a + ~b + 1
  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};
  // overflow: both addends agree in sign, result disagrees
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flag_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  shift_mode_e    mode,
  output logic [W-1:0]   y
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = a;

  // logarithmic barrel: stage i moves by 2**i when amt[i] is set
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [W-1:0] in_v;
    logic [W-1:0] moved;
    assign in_v = stage[i];
    always_comb begin
      unique case (mode)
        SH_LEFT:  moved = {in_v[W-1-D:0], {D{1'b0}}};
        SH_RIGHT: moved = {{D{1'b0}}, in_v[W-1:D]};
        SH_ARITH: moved = {{D{in_v[W-1]}}, in_v[W-1:D]};
        default:  moved = {in_v[W-1-D:0], in_v[W-1:W-D]};
      endcase
    end
    assign stage[i+1] = amt[i] ? moved : in_v;
  end

  assign y = stage[SHW];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  cond_flags_t d,
  output cond_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= d;
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (q == '0));

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic              flag_we,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_n
);
  localparam int MSB = DATA_W - 1;

  alu_op_e      op;
  logic [MSB:0] as_sum;
  logic         as_ovf;
  logic [MSB:0] sh_out;
  cond_flags_t  nxt_flags;
  cond_flags_t  cur_flags;
  logic         is_arith;
  logic         flags_wr;

  assign op = alu_op_e'(op_sel);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (op == OP_SUB),
    .sum (as_sum),
    .ovf (as_ovf)
  );

  alu_shifter #(.W(DATA_W), .SHW(SH_W)) u_shift (
    .a    (opnd_a),
    .amt  (shamt),
    .mode (shift_mode_e'(op_sel[1:0])),
    .y    (sh_out)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = as_sum;
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = opnd_a | opnd_b;
      default:        result = sh_out;
    endcase
  end

  // flag class: only the low half of the opcode space touches the flags
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);
  assign flags_wr  = flag_we && !op_sel[2];

  always_comb begin
    nxt_flags.z = (result == '0);
    nxt_flags.v = is_arith && as_ovf;
    nxt_flags.n = is_arith && (result[MSB] ^ as_ovf);
  end

  alu_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .wr  (flags_wr),
    .d   (nxt_flags),
    .q   (cur_flags)
  );

  assign flag_z = cur_flags.z;
  assign flag_v = cur_flags.v;
  assign flag_n = cur_flags.n;

  assert_zero_tracks_result_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !op_sel[2]) |=> (flag_z == ($past(result) == '0)));

  assert_signed_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == 3'd0) |=>
      (flag_v == (($past(opnd_a[MSB]) == $past(opnd_b[MSB])) &&
                  ($past(result[MSB]) != $past(opnd_a[MSB])))));

  assert_negative_rule_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel[2:1] == 2'b00) |=> (flag_n == ($past(result[MSB]) ^ flag_v)));

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel[2:1] == 2'b01) |=> (!flag_v && !flag_n));

  assert_shift_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
    op_sel[2] |=> ($stable(flag_z) && $stable(flag_v) && $stable(flag_n)));
endmodule

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op_sel;
  logic [15:0] opnd_a, opnd_b;
  logic [3:0]  shamt;
  logic        flag_we;
  logic [15:0] result;
  logic        flag_z, flag_v, flag_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // model state
  bit ez, ev, en;

  always #10 clk = ~clk;

  alu_flags_unit uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .flag_we(flag_we), .result(result),
    .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
  );

  function automatic logic [15:0] ref_res(input logic [2:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic [3:0] s);
    logic [31:0] dbl;
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a << s;
      3'd5: return a >> s;
      3'd6: return 16'($signed(a) >>> s);
      default: begin
        dbl = {a, a} << s;
        return dbl[31:16];
      end
    endcase
  endfunction

  function automatic bit ref_ovf(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    int sa, sb, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    r  = (op == 3'd0) ? sa + sb : sa - sb;
    return (r > 32767) || (r < -32768);
  endfunction

  function automatic string res_tag(input logic [2:0] op);
    if (op < 3'd2) return "R1";
    if (op < 3'd4) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: the edge just passed applied the inputs now on the pins
  task automatic step(input bit r, input logic [2:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic [3:0] s, input bit we);
    string ftag;
    logic [15:0] er;
    bit vo;
    @(negedge clk);
    // combinational result of the present inputs
    chk(res_tag(op_sel), "result", result, ref_res(op_sel, opnd_a, opnd_b, shamt));
    // flag model for the edge that just occurred
    if (rst) begin
      ez = 0; ev = 0; en = 0; ftag = "R10";
    end else if (!flag_we) begin
      ftag = "R9";
    end else if (op_sel[2]) begin
      ftag = "R8";
    end else begin
      er = ref_res(op_sel, opnd_a, opnd_b, shamt);
      ez = (er == 16'h0);
      if (op_sel < 3'd2) begin
        vo = ref_ovf(op_sel, opnd_a, opnd_b);
        ev = vo; en = er[15] ^ vo; ftag = "R5/R6";
      end else begin
        ev = 0; en = 0; ftag = "R7";
      end
    end
    chk("R4", "flag_z", 16'(flag_z), 16'(ez));
    chk(ftag, "flag_v", 16'(flag_v), 16'(ev));
    chk(ftag, "flag_n", 16'(flag_n), 16'(en));
    rst = r; op_sel = op; opnd_a = a; opnd_b = b; shamt = s; flag_we = we;
    @(posedge clk);
  endtask

  initial begin
    rst = 1; op_sel = 0; opnd_a = 0; opnd_b = 0; shamt = 0; flag_we = 0;
    @(posedge clk);
    // reset state (R10) is checked by the first step
    step(0, 3'd0, 16'h7fff, 16'h0001, 0, 1);  // R5 positive overflow, N = 1 xor 1 = 0 (R6)
    step(0, 3'd0, 16'h8000, 16'h8000, 0, 1);  // R4/R5 negative overflow to zero
    step(0, 3'd1, 16'h1234, 16'h1234, 0, 1);  // R4 zero via subtract
    step(0, 3'd1, 16'h8000, 16'h0001, 0, 1);  // R6 overflow with positive raw sign
    step(0, 3'd1, 16'h0003, 16'h0005, 0, 1);  // R6 true negative
    step(0, 3'd4, 16'hffff, 16'h0000, 4'd3, 1); // R8 shift with enable high
    step(0, 3'd2, 16'hf0f0, 16'h0f0f, 0, 1);  // R7 AND to zero
    step(0, 3'd3, 16'h8000, 16'h0001, 0, 1);  // R7 OR with top bit
    step(0, 3'd0, 16'h0000, 16'h0000, 0, 0);  // R9 enable low
    for (int m = 4; m < 8; m++) begin          // R3 shamt 0, 1, 15
      step(0, 3'(m), 16'hb3c5, 16'h0, 4'd0, 1);
      step(0, 3'(m), 16'hb3c5, 16'h0, 4'd1, 1);
      step(0, 3'(m), 16'hb3c5, 16'h0, 4'd15, 0);
    end
    step(0, 3'd1, 16'h8000, 16'h7fff, 0, 1);
    step(1, 3'd1, 16'h8000, 16'h7fff, 0, 1);  // R10 reset wins over enable
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 50) == 0, 3'($urandom), 16'($urandom), 16'($urandom),
           4'($urandom), ($urandom % 4) != 0);
    end
    step(0, 3'd0, 16'h0, 16'h0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule